// File: doc/BRIEF.md
# Bus Data Trace Message Encoder

This block watches a system bus and turns selected data accesses into compact trace messages. An access becomes a message only when four things hold: a designated DMA master made it, its address lies inside a programmed window, its direction is enabled, and its access size is enabled. Each message carries a type code, the master ID, a size code, and the address bits that differ from the previous traced address. The access data follows, cut to the width of the access.

The fields are packed back to back into one wide word starting at bit 0. A length field beside the word reports how many of its bits are meaningful. A downstream queue takes the message over a valid/ready handshake. The encoder has a single output register. A qualifying access that arrives while the register is still waiting for the queue is not traced.

Top module: `dtrace_encoder`

## Requirements
- R1: Only accesses whose master ID equals parameter `DMA_MID` (default 2) produce messages. Accesses from any other master produce no message.
- R2: An access is traced only when `cfg_lo <= bus_addr <= cfg_hi`. The bounds are unsigned and inclusive.
- R3: A write needs `cfg_wr_en` and a read needs `cfg_rd_en`. The bit `cfg_size_en[bus_size]` must also be set.
- R4: Bits 5:0 of a message hold code 000101 for a write and 000110 for a read.
- R5: Bits 9:6 hold the master ID. Bits 12:10 hold the size code. The address delta starts at bit 13, and the data follows directly above the delta.
- R6: The address delta is the current address XOR the previously traced address, with leading zeros removed. The delta is never shorter than 1 bit. The stored previous address resets to 0 and changes only when a message is emitted.
- R7: `bus_size` codes 0, 1, 2 and 3 mean 8, 16, 32 and 64 bits. The size field is written as 000, 001, 010 or 011. The data field holds only the low 8, 16, 32 or 64 data bits.
- R8: `msg_len` equals 13 plus the delta width plus the data width. It lies between 22 and 109. All message bits at or above `msg_len` are zero.
- R9: A message appears one cycle after its access is sampled. It stays unchanged while `msg_valid` is high and `msg_ready` is low. `msg_valid` falls after a handshake if no new message is loaded. `msg_valid` is low after reset.
- R10: A qualifying access that arrives while a message is held without ready is dropped. Such an access does not change the stored address. If ready is high in the same cycle, the new message replaces the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_mid | input | 4 | Master ID of the access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code (0..3 = 8..64 bits) |
| bus_addr | input | 32 | Access address |
| bus_data | input | 64 | Access data |
| cfg_lo | input | 32 | Lower address bound, inclusive |
| cfg_hi | input | 32 | Upper address bound, inclusive |
| cfg_wr_en | input | 1 | Enable tracing of writes |
| cfg_rd_en | input | 1 | Enable tracing of reads |
| cfg_size_en | input | 4 | Per-size trace enable, indexed by size code |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Downstream queue accepts the message |
| msg_data | output | 109 | Packed message, LSB first |
| msg_len | output | 7 | Count of meaningful message bits |

## Verification
The assertions check rules that every cycle must obey. A held message must stay stable. Every valid message must carry a legal type code and the DMA master ID. Its length must stay within bounds and its bits above that length must be zero. Each new message must trace back to a DMA access in the previous cycle. Whether the delta is correct depends on the whole history of traced addresses, so only the bench's scenarios can show it. The same holds for exact data trimming, window and enable filtering, and the dropping of accesses under backpressure. The bench checks these against a reference model of the previous address.

// File: rtl/dtrace_pkg.sv
package dtrace_pkg;
  localparam int HDR_W   = 13;
  localparam int CODE_W  = 6;
  localparam logic [CODE_W-1:0] CODE_WR = 6'b000101;
  localparam logic [CODE_W-1:0] CODE_RD = 6'b000110;
  localparam int SIZE_CODES = 4;

  // width in bits of an access with the given size code
  function automatic int unsigned size_bits(input logic [1:0] sz);
    return 32'd8 << sz;
  endfunction
endpackage

// File: rtl/dtrace_qualify.sv
module dtrace_qualify #(
  parameter int ADDR_W  = 32,
  parameter int MID_W   = 4,
  parameter logic [MID_W-1:0] DMA_MID = 4'd2
) (
  input  logic              bus_valid,
  input  logic [MID_W-1:0]  bus_mid,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ADDR_W-1:0] cfg_lo,
  input  logic [ADDR_W-1:0] cfg_hi,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [dtrace_pkg::SIZE_CODES-1:0] cfg_size_en,
  output logic              qual
);
  localparam int NS = dtrace_pkg::SIZE_CODES;

  logic [NS-1:0] size_hit;
  logic in_window, dir_ok, from_dma;

  // one match term per size code
  for (genvar g = 0; g < NS; g++) begin : g_size
    assign size_hit[g] = (bus_size == 2'(g)) && cfg_size_en[g];
  end

  always_comb begin
    from_dma  = (bus_mid == DMA_MID);
    in_window = (bus_addr >= cfg_lo) && (bus_addr <= cfg_hi);
    dir_ok    = bus_write ? cfg_wr_en : cfg_rd_en;
    qual      = bus_valid && from_dma && in_window && dir_ok && (|size_hit);
  end
endmodule

// File: rtl/dtrace_addr_delta.sv
module dtrace_addr_delta #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 7
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] prev_addr,
  output logic [ADDR_W-1:0] delta,
  output logic [LEN_W-1:0]  delta_len
);
  always_comb begin
    delta     = cur_addr ^ prev_addr;
    delta_len = LEN_W'(1);
    // highest set bit decides the width; zero delta keeps one bit
    for (int i = 0; i < ADDR_W; i++) begin
      if (delta[i]) delta_len = LEN_W'(i + 1);
    end
  end
endmodule

// File: rtl/dtrace_packer.sv
module dtrace_packer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int MID_W  = 4,
  parameter int MSG_W  = 109,
  parameter int LEN_W  = 7
) (
  input  logic              is_write,
  input  logic [MID_W-1:0]  mid,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] delta,
  input  logic [LEN_W-1:0]  delta_len,
  input  logic [DATA_W-1:0] data,
  output logic [MSG_W-1:0]  msg,
  output logic [LEN_W-1:0]  len
);
  import dtrace_pkg::*;

  logic [DATA_W-1:0] data_mask, data_cut;
  logic [MSG_W-1:0]  hdr, delta_ext, data_ext;
  logic [LEN_W-1:0]  data_len;

  always_comb begin
    data_len  = LEN_W'(size_bits(size));
    data_mask = {DATA_W{1'b1}} >> (DATA_W - int'(data_len));
    data_cut  = data & data_mask;
    hdr       = '0;
    hdr[CODE_W-1:0]                 = is_write ? CODE_WR : CODE_RD;
    hdr[CODE_W +: MID_W]            = mid;
    hdr[CODE_W + MID_W +: 3]        = {1'b0, size};
    delta_ext = MSG_W'(delta) << HDR_W;
    data_ext  = MSG_W'(data_cut) << (HDR_W + int'(delta_len));
    msg       = hdr | delta_ext | data_ext;
    len       = LEN_W'(HDR_W) + delta_len + data_len;
  end
endmodule

// File: rtl/dtrace_encoder.sv
module dtrace_encoder #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int MID_W  = 4,
  parameter logic [MID_W-1:0] DMA_MID = 4'd2,
  localparam int MSG_W = dtrace_pkg::HDR_W + ADDR_W + DATA_W,
  localparam int LEN_W = $clog2(MSG_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic [MID_W-1:0]  bus_mid,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [ADDR_W-1:0] cfg_lo,
  input  logic [ADDR_W-1:0] cfg_hi,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [3:0]        cfg_size_en,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [MSG_W-1:0]  msg_data,
  output logic [LEN_W-1:0]  msg_len
);
  import dtrace_pkg::*;

  logic              qual, load;
  logic [ADDR_W-1:0] prev_addr, delta;
  logic [LEN_W-1:0]  delta_len, new_len;
  logic [MSG_W-1:0]  new_msg;

  dtrace_qualify #(.ADDR_W(ADDR_W), .MID_W(MID_W), .DMA_MID(DMA_MID)) u_qual (
    .bus_valid(bus_valid), .bus_mid(bus_mid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_size_en(cfg_size_en),
    .qual(qual)
  );

  dtrace_addr_delta #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_delta (
    .cur_addr(bus_addr), .prev_addr(prev_addr),
    .delta(delta), .delta_len(delta_len)
  );

  dtrace_packer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MID_W(MID_W),
                  .MSG_W(MSG_W), .LEN_W(LEN_W)) u_pack (
    .is_write(bus_write), .mid(bus_mid), .size(bus_size), .delta(delta),
    .delta_len(delta_len), .data(bus_data), .msg(new_msg), .len(new_len)
  );

  // a new message loads when the output slot is free or being drained
  assign load = qual && (!msg_valid || msg_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_data  <= '0;
      msg_len   <= '0;
      prev_addr <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_data  <= new_msg;
      msg_len   <= new_len;
      prev_addr <= bus_addr;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_data) && $stable(msg_len)); // R9
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_data[CODE_W-1:0] == CODE_WR || msg_data[CODE_W-1:0] == CODE_RD)); // R4
  AST_SRC_IS_DMA: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> msg_data[CODE_W +: MID_W] == DMA_MID); // R5
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_len >= LEN_W'(22) && msg_len <= LEN_W'(MSG_W))); // R8
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_data >> msg_len) == '0); // R8
  AST_FROM_DMA: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> $past(bus_valid && bus_mid == DMA_MID)); // R1
endmodule

// File: tb/tb_dtrace_encoder.sv
module tb_dtrace_encoder;
  localparam logic [3:0] DMA = 4'd2;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_valid = 0, bus_write = 0, msg_ready = 0;
  logic [3:0] bus_mid = 0;
  logic [1:0] bus_size = 0;
  logic [31:0] bus_addr = 0, cfg_lo = 0, cfg_hi = 32'hFFFF_FFFF;
  logic [63:0] bus_data = 0;
  logic cfg_wr_en = 1, cfg_rd_en = 1;
  logic [3:0] cfg_size_en = 4'hF;
  logic msg_valid;
  logic [108:0] msg_data;
  logic [6:0] msg_len;

  int checks = 0, fails = 0;
  logic ev = 0;
  logic [108:0] em = '0;
  logic [6:0] el = '0;
  logic [31:0] prev_m = '0;

  always #5 clk = ~clk;

  dtrace_encoder dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_mid(bus_mid),
    .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_data(bus_data), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_size_en(cfg_size_en),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data),
    .msg_len(msg_len)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void build(input logic [31:0] a, input logic [31:0] p,
      input logic [63:0] d, input logic [1:0] sz, input logic wr,
      output logic [108:0] m, output logic [6:0] l);
    logic [31:0] x;
    logic [63:0] dm;
    int n, db;
    x = a ^ p;
    n = 1;
    for (int i = 0; i < 32; i++) if (x[i]) n = i + 1;
    db = 8 << sz;
    dm = (db == 64) ? d : (d & ((64'd1 << db) - 64'd1));
    m = '0;
    m[5:0] = wr ? 6'b000101 : 6'b000110;
    m[9:6] = DMA;
    m[12:10] = {1'b0, sz};
    m = m | (109'(x) << 13) | (109'(dm) << (13 + n));
    l = 7'(13 + n + db);
  endfunction

  // drive one cycle of stimulus, advance the reference model, compare
  task automatic step(input logic v, input logic [31:0] a, input logic [63:0] d,
                      input logic [1:0] sz, input logic wr, input logic [3:0] mid,
                      input logic rdy, input string tag);
    logic q;
    bus_valid = v; bus_addr = a; bus_data = d; bus_size = sz;
    bus_write = wr; bus_mid = mid; msg_ready = rdy;
    q = v && (mid == DMA) && (a >= cfg_lo) && (a <= cfg_hi) &&
        (wr ? cfg_wr_en : cfg_rd_en) && cfg_size_en[sz];
    if (q && (!ev || rdy)) begin
      build(a, prev_m, d, sz, wr, em, el);
      prev_m = a;
      ev = 1'b1;
    end else if (rdy) begin
      ev = 1'b0;
    end
    @(negedge clk);
    chk(msg_valid === ev, tag, "valid", 128'(msg_valid), 128'(ev));
    if (ev) begin
      chk(msg_data[5:0] === em[5:0], "R4", "code", 128'(msg_data[5:0]), 128'(em[5:0]));
      chk(msg_data[12:6] === em[12:6], "R5", "src/size", 128'(msg_data[12:6]), 128'(em[12:6]));
      chk(msg_data === em, tag, "message", 128'(msg_data), 128'(em));
      chk(msg_len === el, "R8", "length", 128'(msg_len), 128'(el));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(msg_valid === 1'b0, "R9", "reset valid", 128'(msg_valid), 128'(0));

    // R6 first message carries the full significant address; R7 byte trim
    step(1, 32'h8000_0010, 64'h1122_3344_5566_77AB, 2'd0, 1, DMA, 1, "R6");
    // R6 same address again gives one zero delta bit; R7 full 64-bit data
    step(1, 32'h8000_0010, 64'hDEAD_BEEF_CAFE_F00D, 2'd3, 0, DMA, 1, "R6");
    // R8 top bit differs and access is 64 bits: 109-bit message
    step(1, 32'h0000_0010, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1, DMA, 1, "R8");
    step(0, 0, 0, 0, 0, DMA, 1, "R9");
    // R1 foreign master ignored
    step(1, 32'h0000_0020, 64'h5, 2'd1, 1, 4'd7, 1, "R1");
    // R2 window bounds inclusive
    cfg_lo = 32'h0000_1000; cfg_hi = 32'h0000_1FFF;
    step(1, 32'h0000_0FFF, 64'h1, 2'd2, 1, DMA, 1, "R2");
    step(1, 32'h0000_2000, 64'h2, 2'd2, 1, DMA, 1, "R2");
    step(1, 32'h0000_1000, 64'h3, 2'd2, 1, DMA, 1, "R2");
    step(1, 32'h0000_1FFF, 64'h4, 2'd1, 0, DMA, 1, "R2");
    // R3 direction and size enables
    cfg_wr_en = 0;
    step(1, 32'h0000_1234, 64'h6, 2'd2, 1, DMA, 1, "R3");
    step(1, 32'h0000_1234, 64'h7, 2'd2, 0, DMA, 1, "R3");
    cfg_wr_en = 1; cfg_rd_en = 0;
    step(1, 32'h0000_1235, 64'h8, 2'd2, 0, DMA, 1, "R3");
    cfg_rd_en = 1; cfg_size_en = 4'b1011;
    step(1, 32'h0000_1300, 64'h9, 2'd2, 1, DMA, 1, "R3");
    step(1, 32'h0000_1300, 64'h9, 2'd1, 1, DMA, 1, "R3");
    cfg_size_en = 4'hF;
    // R9/R10 held message, dropped access keeps previous address
    step(1, 32'h0000_1400, 64'hA1, 2'd0, 1, DMA, 0, "R9");
    step(1, 32'h0000_1FF0, 64'hA2, 2'd0, 1, DMA, 0, "R10");
    step(0, 0, 0, 0, 0, DMA, 0, "R9");
    step(1, 32'h0000_1401, 64'hA3, 2'd1, 0, DMA, 1, "R10");
    step(1, 32'h0000_1403, 64'hA4, 2'd2, 1, DMA, 1, "R10");
    step(0, 0, 0, 0, 0, DMA, 1, "R9");

    // random traffic
    cfg_lo = 32'h1000_0000; cfg_hi = 32'h8FFF_FFFF;
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] a;
      logic [3:0] mid;
      if (k % 500 == 0) begin
        cfg_wr_en = ($urandom % 5) != 0;
        cfg_rd_en = ($urandom % 5) != 0;
        cfg_size_en = 4'($urandom) | 4'b0001;
      end
      if ($urandom % 2 == 0) a = prev_m ^ ($urandom & ((32'd1 << ($urandom % 32)) - 1));
      else a = $urandom;
      mid = ($urandom % 6 == 0) ? 4'($urandom) : DMA;
      step(($urandom % 4) != 0, a, {$urandom, $urandom}, 2'($urandom), 1'($urandom),
           mid, ($urandom % 3) != 0, "R6");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule